// File: doc/BRIEF.md
# Zero-Return Hysteresis Frequency Counter

This block watches a stream of converter samples, each qualified by a valid strobe. It estimates the frequency of the signal by counting cycles over a gate window of programmable length, normally one second of system clocks. A cycle is counted only when two things happen in order. First, the signal stays above a high threshold for a required run of consecutive samples. Then it drops all the way to zero. Samples between zero and the threshold neither count nor disarm, so the gap between zero and the threshold works as a Schmitt-style dead band.

Over the same window the block also tracks the smallest sample, the largest sample and how many valid samples arrived. A start pulse captures the threshold, the required run and the window length, clears every accumulator and opens the window. When the window closes, the four results are latched onto the result ports and done goes high. Done stays high until the next start, and samples that arrive in the meantime are ignored.

Top module: `zero_return_freq_counter`

## Requirements
- R1: After reset, done is 0 and freqCount, maxSample, minSample and sampleCount are all 0.
- R2: A start pulse captures thresholdIn, runReqIn and windowLenIn, clears all accumulators (the maximum to 0, the minimum to all ones), and drives done to 0 from the following cycle. A sample presented in the start cycle is ignored.
- R3: The window spans the windowLenIn clock cycles that follow the start cycle. done rises at the clock edge that ends the last of those cycles. A windowLenIn of 0 acts as 1.
- R4: A sample strictly greater than the captured threshold is classed as above. Any other sample is classed as below.
- R5: On an above sample, if the run counter is already at or over the captured run requirement, the block becomes armed. Otherwise the run counter increments. Arming therefore needs runReq+1 consecutive above samples, and any below sample clears the run counter.
- R6: A sample equal to 0 while armed increments the frequency count. Any zero sample clears the armed state.
- R7: A below sample from 1 up to the threshold leaves the armed state and the frequency count unchanged.
- R8: Each accepted sample increments the sample count and updates the running minimum and maximum. The latched results report these values for the window.
- R9: After the window closes, done stays 1 and the result ports hold their values until the next start, whatever samples arrive.
- R10: A sample accepted in the last cycle of the window is included in the latched results.
- R11: A start pulse during an open window abandons that window and begins a fresh one with the newly captured settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that captures settings and opens a window |
| sampleValid | input | 1 | Qualifies sampleData in this cycle |
| sampleData | input | SAMPLE_W | Converter sample |
| thresholdIn | input | SAMPLE_W | High threshold, captured at start |
| runReqIn | input | RUN_W | Above-run needed before arming, captured at start |
| windowLenIn | input | WIN_W | Window length in clock cycles, captured at start |
| done | output | 1 | Results valid, held until next start |
| freqCount | output | CNT_W | Zero-return cycles counted in the window |
| maxSample | output | SAMPLE_W | Largest sample in the window |
| minSample | output | SAMPLE_W | Smallest sample in the window |
| sampleCount | output | CNT_W | Valid samples accepted in the window |

## Verification
Two functions can meet in one cycle: the expiry of the window and the acceptance of a sample. The worst case is a zero sample that completes a counted cycle exactly on the closing edge. A directed sequence is sized so that its final zero, arriving while armed, lands on the last window cycle. The latched frequency, minimum, maximum and sample count must then include it. Random windows of random length also end on a valid sample about three times in four. A bench model that applies the requirement rules sample by sample gives the expected values, and these are compared after done rises.

// File: rtl/zfc_pkg.sv
`timescale 1ns/1ps
package zfc_pkg;
  // Strobes issued by the window control towards the datapath
  typedef struct packed {
    logic init;    // reinitialise accumulators (start pulse)
    logic accept;  // a valid sample inside the open window
    logic finish;  // last cycle of the window: latch results
  } zfcStrobe_t;
endpackage

// File: rtl/zfc_ctrl.sv
`timescale 1ns/1ps
module zfc_ctrl
  import zfc_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int RUN_W    = 8,
  parameter int WIN_W    = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] thresholdIn,
  input  logic [RUN_W-1:0]    runReqIn,
  input  logic [WIN_W-1:0]    windowLenIn,
  output zfcStrobe_t          strb,
  output logic [SAMPLE_W-1:0] thrQ,
  output logic [RUN_W-1:0]    runReqQ,
  output logic                done
);
  localparam logic [WIN_W-1:0] ONE = WIN_W'(1);

  logic             busy;
  logic [WIN_W-1:0] timer;
  logic [WIN_W-1:0] winLenQ;
  logic             lastCycle;

  assign lastCycle   = busy && (timer == winLenQ - ONE);
  assign strb.init   = start;
  assign strb.accept = busy && sampleValid && !start;
  assign strb.finish = lastCycle && !start;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      timer   <= '0;
      winLenQ <= ONE;
      thrQ    <= '0;
      runReqQ <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      done    <= 1'b0;
      timer   <= '0;
      winLenQ <= (windowLenIn == '0) ? ONE : windowLenIn;
      thrQ    <= thresholdIn;
      runReqQ <= runReqIn;
    end else if (busy) begin
      if (lastCycle) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        timer <= timer + ONE;
      end
    end
  end

  // R9: done only falls because of a start pulse
  assert_done_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(done) |-> $past(start));

  // R3: done rises only at the end of an open window
  assert_done_after_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy));

  // R3: window open and results ready are exclusive
  assert_busy_done_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));
endmodule

// File: rtl/zfc_datapath.sv
`timescale 1ns/1ps
module zfc_datapath
  import zfc_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int RUN_W    = 8,
  parameter int CNT_W    = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  zfcStrobe_t          strb,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [SAMPLE_W-1:0] thrQ,
  input  logic [RUN_W-1:0]    runReqQ,
  output logic [CNT_W-1:0]    freqOut,
  output logic [SAMPLE_W-1:0] maxOut,
  output logic [SAMPLE_W-1:0] minOut,
  output logic [CNT_W-1:0]    cntOut
);
  localparam logic [SAMPLE_W-1:0] MIN_INIT = {SAMPLE_W{1'b1}};
  localparam logic [CNT_W-1:0]    CNT_ONE  = CNT_W'(1);
  localparam logic [RUN_W-1:0]    RUN_ONE  = RUN_W'(1);

  logic [RUN_W-1:0]    runAcc, runNext;
  logic                armedAcc, armedNext;
  logic [CNT_W-1:0]    freqAcc, freqNext;
  logic [CNT_W-1:0]    cntAcc, cntNext;
  logic [SAMPLE_W-1:0] minAcc, minNext;
  logic [SAMPLE_W-1:0] maxAcc, maxNext;
  logic                isAbove, isZero;

  assign isAbove = sampleData > thrQ;
  assign isZero  = (sampleData == '0);

  always_comb begin
    runNext   = runAcc;
    armedNext = armedAcc;
    freqNext  = freqAcc;
    cntNext   = cntAcc;
    minNext   = minAcc;
    maxNext   = maxAcc;
    if (strb.accept) begin
      cntNext = cntAcc + CNT_ONE;
      if (sampleData < minAcc) minNext = sampleData;
      if (sampleData > maxAcc) maxNext = sampleData;
      if (isAbove) begin
        if (runAcc >= runReqQ) armedNext = 1'b1;
        else                   runNext   = runAcc + RUN_ONE;
      end else begin
        runNext = '0;
        if (isZero) begin
          if (armedAcc) freqNext = freqAcc + CNT_ONE;
          armedNext = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runAcc   <= '0;
      armedAcc <= 1'b0;
      freqAcc  <= '0;
      cntAcc   <= '0;
      minAcc   <= MIN_INIT;
      maxAcc   <= '0;
    end else if (strb.init) begin
      runAcc   <= '0;
      armedAcc <= 1'b0;
      freqAcc  <= '0;
      cntAcc   <= '0;
      minAcc   <= MIN_INIT;
      maxAcc   <= '0;
    end else begin
      runAcc   <= runNext;
      armedAcc <= armedNext;
      freqAcc  <= freqNext;
      cntAcc   <= cntNext;
      minAcc   <= minNext;
      maxAcc   <= maxNext;
    end
  end

  // Results take the next-state values so a last-cycle sample is included
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freqOut <= '0;
      maxOut  <= '0;
      minOut  <= '0;
      cntOut  <= '0;
    end else if (strb.finish) begin
      freqOut <= freqNext;
      maxOut  <= maxNext;
      minOut  <= minNext;
      cntOut  <= cntNext;
    end
  end

  // R6: frequency accumulator never steps by more than one
  assert_freq_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.init |=> (freqAcc - $past(freqAcc)) <= CNT_ONE);

  // R5: arming only follows an accepted above sample
  assert_arm_on_above_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armedAcc) |-> $past(strb.accept && isAbove));

  // R8: once any sample is seen, minimum never exceeds maximum
  assert_min_le_max_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cntAcc != '0) |-> (minAcc <= maxAcc));

  // R9: result ports move only on a finish strobe
  assert_results_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.finish |=> ($stable(freqOut) && $stable(cntOut) && $stable(minOut) && $stable(maxOut)));
endmodule

// File: rtl/zero_return_freq_counter.sv
`timescale 1ns/1ps
module zero_return_freq_counter
  import zfc_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int RUN_W    = 8,
  parameter int WIN_W    = 32,
  parameter int CNT_W    = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [SAMPLE_W-1:0] thresholdIn,
  input  logic [RUN_W-1:0]    runReqIn,
  input  logic [WIN_W-1:0]    windowLenIn,
  output logic                done,
  output logic [CNT_W-1:0]    freqCount,
  output logic [SAMPLE_W-1:0] maxSample,
  output logic [SAMPLE_W-1:0] minSample,
  output logic [CNT_W-1:0]    sampleCount
);
  zfcStrobe_t          strb;
  logic [SAMPLE_W-1:0] thrQ;
  logic [RUN_W-1:0]    runReqQ;

  zfc_ctrl #(.SAMPLE_W(SAMPLE_W), .RUN_W(RUN_W), .WIN_W(WIN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .sampleValid(sampleValid),
    .thresholdIn(thresholdIn), .runReqIn(runReqIn), .windowLenIn(windowLenIn),
    .strb(strb), .thrQ(thrQ), .runReqQ(runReqQ), .done(done)
  );

  zfc_datapath #(.SAMPLE_W(SAMPLE_W), .RUN_W(RUN_W), .CNT_W(CNT_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .sampleData(sampleData),
    .thrQ(thrQ), .runReqQ(runReqQ),
    .freqOut(freqCount), .maxOut(maxSample), .minOut(minSample), .cntOut(sampleCount)
  );
endmodule

// File: tb/zero_return_freq_counter_bench.sv
`timescale 1ns/1ps
module zero_return_freq_counter_bench;
  localparam int SW = 10;
  localparam int RW = 8;
  localparam int WW = 32;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          sampleValid = 1'b0;
  logic [SW-1:0] sampleData = '0;
  logic [SW-1:0] thresholdIn = '0;
  logic [RW-1:0] runReqIn = '0;
  logic [WW-1:0] windowLenIn = '0;
  logic          done;
  logic [CW-1:0] freqCount, sampleCount;
  logic [SW-1:0] maxSample, minSample;

  int checks = 0;
  int fails = 0;
  int directed[$];

  // reference state
  int mRun, mArmed, mFreq, mCnt, mMin, mMax, mThr, mReq;

  always #2 clk = ~clk;

  zero_return_freq_counter #(.SAMPLE_W(SW), .RUN_W(RW), .WIN_W(WW), .CNT_W(CW))
    u_zero_return_freq_counter (
      .clk(clk), .rstN(rstN), .start(start), .sampleValid(sampleValid),
      .sampleData(sampleData), .thresholdIn(thresholdIn), .runReqIn(runReqIn),
      .windowLenIn(windowLenIn), .done(done), .freqCount(freqCount),
      .maxSample(maxSample), .minSample(minSample), .sampleCount(sampleCount));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic modelInit(input int thr, input int rq);
    mRun = 0; mArmed = 0; mFreq = 0; mCnt = 0;
    mMin = (1 << SW) - 1; mMax = 0; mThr = thr; mReq = rq;
  endtask

  task automatic modelSample(input int v);
    mCnt++;
    if (v < mMin) mMin = v;
    if (v > mMax) mMax = v;
    if (v > mThr) begin
      if (mRun >= mReq) mArmed = 1; else mRun++;
    end else begin
      mRun = 0;
      if (v == 0) begin
        if (mArmed != 0) mFreq++;
        mArmed = 0;
      end
    end
  endtask

  function automatic int pickSample(input int thr);
    int r;
    r = int'($urandom % 4);
    if (r == 0) return 0;
    if (r == 1 && thr > 0) return 1 + int'($urandom % thr);
    return thr + 1 + int'($urandom % 40);
  endfunction

  task automatic pulseStart(input int thr, input int rq, input int len);
    @(negedge clk);
    start = 1'b1; thresholdIn = SW'(thr); runReqIn = RW'(rq); windowLenIn = WW'(len);
    sampleValid = 1'b1; sampleData = '0; // start-cycle sample must be ignored (R2)
    @(posedge clk);
  endtask

  task automatic driveCycle(input int thr);
    int v;
    bit vld;
    if (directed.size() > 0) begin
      v = directed.pop_front();
      vld = 1'b1;
    end else begin
      v = pickSample(thr);
      vld = ($urandom % 4) != 0;
    end
    sampleValid = vld;
    sampleData = SW'(v);
    if (vld) modelSample(v);
    @(posedge clk);
  endtask

  task automatic runWindow(input string tag, input int thr, input int rq, input int len);
    int eff;
    eff = (len == 0) ? 1 : len;
    pulseStart(thr, rq, len);
    modelInit(thr, rq);
    for (int i = 0; i < eff; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (i == 0) chk({tag, " R2 done low after start"}, done, 0);
      if (i == eff - 1) chk({tag, " R3 done low before last edge"}, done, 0);
      driveCycle(thr);
    end
    @(negedge clk);
    sampleValid = 1'b0;
    chk({tag, " R3 done at window end"}, done, 1);
    chk({tag, " R6 freqCount"}, freqCount, mFreq);
    chk({tag, " R8 sampleCount"}, sampleCount, mCnt);
    chk({tag, " R8 minSample"}, minSample, mMin);
    chk({tag, " R8 maxSample"}, maxSample, mMax);
  endtask

  task automatic idleIgnored(input string tag, input int n);
    logic [CW-1:0] f, c;
    logic [SW-1:0] mn, mx;
    f = freqCount; c = sampleCount; mn = minSample; mx = maxSample;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sampleValid = 1'b1;
      sampleData = SW'(i[0] ? 0 : 900);
    end
    @(negedge clk);
    sampleValid = 1'b0;
    chk({tag, " R9 done held"}, done, 1);
    chk({tag, " R9 freq held"}, freqCount, f);
    chk({tag, " R9 count held"}, sampleCount, c);
    chk({tag, " R9 min held"}, minSample, mn);
    chk({tag, " R9 max held"}, maxSample, mx);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 done reset", done, 0);
    chk("R1 freq reset", freqCount, 0);
    chk("R1 count reset", sampleCount, 0);
    chk("R1 min reset", minSample, 0);
    chk("R1 max reset", maxSample, 0);
    rstN = 1'b1;

    // Directed R4 R5 R7 R10: threshold 4, run 2; final zero on the closing cycle counts
    directed = '{5, 3, 6, 7, 0,   5, 6, 0,   5, 6, 7, 0,   4, 5, 6, 7, 3, 0};
    runWindow("directed", 4, 2, 18);
    chk("R10 directed freq includes last-cycle zero", freqCount, 2);
    chk("R4 directed max", maxSample, 7);
    idleIgnored("after directed", 6);

    // R7: gap samples after arming keep it armed; threshold sample is below (R4)
    directed = '{9, 9, 4, 1, 3, 0, 4, 4, 0};
    runWindow("gap", 4, 1, 9);
    chk("R7 gap keeps arm", freqCount, 1);

    // R5: run requirement 0 arms on first above sample
    directed = '{1, 0, 2, 0, 1, 0};
    runWindow("req0", 0, 0, 6);
    chk("R5 run 0 arms immediately", freqCount, 3);

    // R3: zero length acts as one
    directed = '{17};
    runWindow("zerolen", 4, 2, 0);
    chk("R3 zero length count", sampleCount, 1);

    // R11: restart mid-window
    pulseStart(3, 1, 50);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      start = 1'b0;
      sampleValid = 1'b1;
      sampleData = SW'(i[0] ? 0 : 800);
      @(posedge clk);
    end
    runWindow("restart R11", 6, 3, 40);
    chk("R11 restart min ignores old window", (minSample == 0 || mCnt == 0) ? 1 : (minSample != 800 ? 1 : 0), 1);

    // Random windows
    for (int w = 0; w < 8; w++) begin
      int thr, rq, len;
      thr = 1 + int'($urandom % 20);
      rq  = int'($urandom % 5);
      len = 30 + int'($urandom % 170);
      runWindow($sformatf("random%0d", w), thr, rq, len);
    end
    idleIgnored("after random", 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule